// File: doc/BRIEF.md
# PS/2 Device-Side Byte Transmitter

This block sends single bytes from a pointing device to its host over the two-wire open-drain PS/2 bus. The device is the one that generates the clock. A byte arrives on a valid/ready handshake and is stored in an internal frame buffer. The block then waits until both bus lines have been idle for long enough. After that it clocks out an 11-bit frame. It drives each wire by asserting a pull-low enable and otherwise lets the wire float high.

Timing is derived from a one-cycle tick supplied by an external prescaler. With the defaults of a 10 µs tick, each clock half-period is four ticks (40 µs) and the idle wait is five ticks (50 µs). During each released half of the generated clock, the block checks on every tick whether the host is holding CLK low. Contention seen before the tenth rising edge aborts the frame. The block then releases both lines and keeps the byte. It sends the byte again on its own once the bus has been idle again. Contention seen after the tenth rising edge is ignored, and the frame runs to completion.

Top module: `ps2_dev_tx`

## Requirements
- R1: A frame is 11 bits, each read by the host at a falling edge of the generated clock: bit 0 is a start bit of 0, bits 1 to 8 are the byte LSB first, bit 9 is odd parity over the byte, and bit 10 is a stop bit of 1. `dat_pull_o` = 1 means the data line is driven low.
- R2: The data pull enable changes only while the generated clock is released. It holds its value through every low phase of the clock.
- R3: Every low phase of the generated clock lasts exactly HALF_TICKS ticks, and every high phase between two low phases of one frame also lasts exactly HALF_TICKS ticks.
- R4: While the bus clock line is held low by the host, no frame is started and no clock pulse is generated.
- R5: While the host requests to send (bus clock high, bus data low), no frame is started.
- R6: A frame starts only after both bus lines have been high for IDLE_TICKS consecutive ticks. Any cycle with a line low restarts this wait, and the first clock falling edge follows the start by HALF_TICKS/2 ticks.
- R7: If the bus clock is seen low on a tick during a released clock phase before the tenth rising edge, the frame is aborted. `aborted_o` pulses for one cycle, and both pull enables are deasserted in that same cycle.
- R8: An accepted byte is kept until its frame completes: after an abort the same byte is resent, and `in_ready_o` stays low from acceptance until completion, so bytes offered meanwhile are not taken.
- R9: Once the tenth rising edge has passed, a low bus clock is ignored and the frame completes normally.
- R10: `done_o` pulses for exactly one cycle per completed frame, never together with `aborted_o`. `in_ready_o` is high in that cycle.
- R11: After reset both pull enables, `done_o` and `aborted_o` are low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle bit-rate tick from the prescaler |
| in_valid_i | input | 1 | Byte offered |
| in_data_i | input | 8 | Byte to send |
| in_ready_o | output | 1 | Block can accept a byte |
| bus_clk_i | input | 1 | Sampled level of the bus clock wire |
| bus_dat_i | input | 1 | Sampled level of the bus data wire |
| clk_pull_o | output | 1 | Drive the bus clock wire low |
| dat_pull_o | output | 1 | Drive the bus data wire low |
| done_o | output | 1 | One-cycle pulse: frame completed |
| aborted_o | output | 1 | One-cycle pulse: frame aborted by the host |

## Verification
Some properties are checked on every cycle by the assertions. Data is held steady while the clock is pulled low, and lines are released in the abort cycle. Abort and done pulses last one cycle and never coincide. The block is never ready while it is driving the clock, and a frame starts only from an idle bus. Never aborting past the commit point is also checked each cycle. Other behaviour only the bench scenarios can show: the bit content of each frame across all 256 byte values, the exact low and high widths, the idle-wait latency after release or after a glitch, and that the retried byte is the original one. They also show how the outcome depends on the clock edge at which the host intervenes.

// File: rtl/ps2_tx_pkg.sv
package ps2_tx_pkg;

    localparam int FRAME_BITS = 11;
    localparam int COMMIT_IDX = 9;   // bit whose clock rise ends the abort window
    localparam int LAST_IDX   = FRAME_BITS - 1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAIT,
        PH_SETUP,
        PH_LOW,
        PH_HOLD
    } tx_phase_e;

    // Packed LSB first: the last member sits at bit 0 and goes out first.
    typedef struct packed {
        logic       stop;
        logic       parity;
        logic [7:0] payload;
        logic       start;
    } tx_frame_t;

    function automatic tx_frame_t make_frame(input logic [7:0] b);
        tx_frame_t f;
        f.start   = 1'b0;
        f.payload = b;
        f.parity  = ~^b;
        f.stop    = 1'b1;
        return f;
    endfunction

    function automatic logic frame_bit(input tx_frame_t f, input logic [3:0] i);
        logic [FRAME_BITS-1:0] v;
        v = f >> i;
        return (32'(i) < FRAME_BITS) ? v[0] : 1'b1;
    endfunction

endpackage

// File: rtl/ps2_tx_buffer.sv
module ps2_tx_buffer
    import ps2_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    input  logic [3:0] idx_i,
    output logic       bit_o
);

    tx_frame_t frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= make_frame(8'h00);
        end else if (load_i) begin
            frame_q <= make_frame(byte_i);
        end
    end

    assign bit_o = frame_bit(frame_q, idx_i);

endmodule

// File: rtl/ps2_tx_idle_timer.sv
module ps2_tx_idle_timer #(
    parameter int IDLE_TICKS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic tick_i,
    input  logic bus_clk_i,
    input  logic bus_dat_i,
    output logic go_o
);

    localparam int IW = (IDLE_TICKS > 1) ? $clog2(IDLE_TICKS) : 1;

    logic [IW-1:0] cnt_q;
    logic          both_high;

    assign both_high = bus_clk_i && bus_dat_i;

    always_ff @(posedge clk) begin
        if (rst || !arm_i || !both_high) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (cnt_q == IW'(IDLE_TICKS - 1)) cnt_q <= '0;
            else                              cnt_q <= cnt_q + 1'b1;
        end
    end

    assign go_o = arm_i && tick_i && both_high && (cnt_q == IW'(IDLE_TICKS - 1));

endmodule

// File: rtl/ps2_tx_engine.sv
module ps2_tx_engine
    import ps2_tx_pkg::*;
#(
    parameter int HALF_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       bus_clk_i,
    input  logic       bus_dat_i,
    input  logic       in_valid_i,
    output logic       in_ready_o,
    output logic       load_o,
    input  logic       go_i,
    output logic       arm_o,
    output logic [3:0] idx_o,
    input  logic       frame_bit_i,
    output logic       clk_pull_o,
    output logic       dat_pull_o,
    output logic       done_o,
    output logic       aborted_o
);

    localparam int SETUP_TICKS = HALF_TICKS / 2;
    localparam int HOLD_TICKS  = HALF_TICKS - SETUP_TICKS;
    localparam int CW          = $clog2(HALF_TICKS);

    tx_phase_e     phase_q;
    logic [CW-1:0] cnt_q;
    logic [3:0]    idx_q;
    logic          done_q;
    logic          abort_q;
    logic          committed;
    logic          contend;

    assign committed = (idx_q > 4'(COMMIT_IDX)) ||
                       (idx_q == 4'(COMMIT_IDX) && phase_q == PH_HOLD);
    assign contend   = !bus_clk_i && !committed;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            done_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            abort_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (in_valid_i) phase_q <= PH_WAIT;
                end
                PH_WAIT: begin
                    if (go_i) begin
                        phase_q <= PH_SETUP;
                        cnt_q   <= '0;
                        idx_q   <= '0;
                    end
                end
                PH_SETUP: begin
                    if (tick_i) begin
                        if (contend) begin
                            phase_q <= PH_WAIT;
                            abort_q <= 1'b1;
                            cnt_q   <= '0;
                            idx_q   <= '0;
                        end else if (cnt_q == CW'(SETUP_TICKS - 1)) begin
                            phase_q <= PH_LOW;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                PH_LOW: begin
                    if (tick_i) begin
                        if (cnt_q == CW'(HALF_TICKS - 1)) begin
                            phase_q <= PH_HOLD;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                PH_HOLD: begin
                    if (tick_i) begin
                        if (contend) begin
                            phase_q <= PH_WAIT;
                            abort_q <= 1'b1;
                            cnt_q   <= '0;
                            idx_q   <= '0;
                        end else if (cnt_q == CW'(HOLD_TICKS - 1)) begin
                            cnt_q <= '0;
                            if (idx_q == 4'(LAST_IDX)) begin
                                phase_q <= PH_IDLE;
                                done_q  <= 1'b1;
                                idx_q   <= '0;
                            end else begin
                                phase_q <= PH_SETUP;
                                idx_q   <= idx_q + 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign in_ready_o = (phase_q == PH_IDLE);
    assign load_o     = in_ready_o && in_valid_i;
    assign arm_o      = (phase_q == PH_WAIT);
    assign idx_o      = idx_q;
    assign clk_pull_o = (phase_q == PH_LOW);
    assign dat_pull_o = (phase_q == PH_SETUP || phase_q == PH_LOW || phase_q == PH_HOLD)
                        && !frame_bit_i;
    assign done_o     = done_q;
    assign aborted_o  = abort_q;

    // R2: data held through the whole low phase
    assert_dat_steady_low_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LOW && $past(phase_q) == PH_LOW) |-> $stable(dat_pull_o));

    // R4/R5/R6: a frame only leaves the wait state from an idle bus
    assert_start_from_idle_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(phase_q) == PH_WAIT && phase_q == PH_SETUP)
            |-> ($past(bus_clk_i) && $past(bus_dat_i)));

    // R7: abort releases both wires
    assert_abort_release_R7: assert property (@(posedge clk) disable iff (rst)
        aborted_o |-> (!clk_pull_o && !dat_pull_o));

    // R7: abort is a single-cycle pulse
    assert_abort_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        aborted_o |=> !aborted_o);

    // R9: no abort once past the commit bit
    assert_no_late_abort_R9: assert property (@(posedge clk) disable iff (rst)
        aborted_o |-> ($past(idx_q) <= 4'(COMMIT_IDX)));

    // R8: never ready while driving the clock
    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
        clk_pull_o |-> !in_ready_o);

    // R10: done and abort are exclusive single-cycle pulses
    assert_done_excl_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!aborted_o && in_ready_o));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // bus_dat_i is only used by the idle timer; engine keeps it for checks
    logic unused_dat;
    assign unused_dat = bus_dat_i;

endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx #(
    parameter int HALF_TICKS = 4,
    parameter int IDLE_TICKS = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       in_valid_i,
    input  logic [7:0] in_data_i,
    output logic       in_ready_o,
    input  logic       bus_clk_i,
    input  logic       bus_dat_i,
    output logic       clk_pull_o,
    output logic       dat_pull_o,
    output logic       done_o,
    output logic       aborted_o
);

    logic       load;
    logic       arm;
    logic       go;
    logic [3:0] idx;
    logic       fbit;

    ps2_tx_buffer u_buf (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .byte_i (in_data_i),
        .idx_i  (idx),
        .bit_o  (fbit)
    );

    ps2_tx_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
        .clk       (clk),
        .rst       (rst),
        .arm_i     (arm),
        .tick_i    (tick_i),
        .bus_clk_i (bus_clk_i),
        .bus_dat_i (bus_dat_i),
        .go_o      (go)
    );

    ps2_tx_engine #(.HALF_TICKS(HALF_TICKS)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .bus_clk_i   (bus_clk_i),
        .bus_dat_i   (bus_dat_i),
        .in_valid_i  (in_valid_i),
        .in_ready_o  (in_ready_o),
        .load_o      (load),
        .go_i        (go),
        .arm_o       (arm),
        .idx_o       (idx),
        .frame_bit_i (fbit),
        .clk_pull_o  (clk_pull_o),
        .dat_pull_o  (dat_pull_o),
        .done_o      (done_o),
        .aborted_o   (aborted_o)
    );

endmodule

// File: tb/ps2_dev_tx_tb.sv
`timescale 1ns/1ps
module ps2_dev_tx_tb_top;

    localparam int HALF  = 4;
    localparam int IDLE  = 5;
    localparam int P     = 2;              // cycles per tick
    localparam int SETUP = HALF / 2;
    localparam int PHW   = HALF * P;       // expected phase width in cycles

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic host_clk_low = 1'b0;
    logic host_dat_low = 1'b0;
    logic in_ready, clk_pull, dat_pull, done, aborted;
    logic bus_clk, bus_dat;

    int errors = 0;
    int checks = 0;

    assign bus_clk = !(clk_pull || host_clk_low);
    assign bus_dat = !(dat_pull || host_dat_low);

    always #2.5 clk = ~clk;

    ps2_dev_tx #(.HALF_TICKS(HALF), .IDLE_TICKS(IDLE)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .in_valid_i (in_valid),
        .in_data_i  (in_data),
        .in_ready_o (in_ready),
        .bus_clk_i  (bus_clk),
        .bus_dat_i  (bus_dat),
        .clk_pull_o (clk_pull),
        .dat_pull_o (dat_pull),
        .done_o     (done),
        .aborted_o  (aborted)
    );

    always @(negedge clk) tick <= ~tick;

    // Host-side monitor
    logic        prev_cp = 1'b0;
    logic        prev_dp = 1'b0;
    logic [10:0] sr = '0;
    int rises = 0, falls = 0, lowlen = 0, highlen = 0;
    int width_err = 0, steady_err = 0, ready_err = 0;
    int done_cnt = 0, abort_cnt = 0, both_err = 0;
    logic mid = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (clk_pull) begin
                if (!prev_cp) begin
                    falls <= falls + 1;
                    sr <= {!dat_pull, sr[10:1]};
                    if (mid && highlen != PHW) width_err <= width_err + 1;
                    lowlen <= 1;
                end else begin
                    lowlen <= lowlen + 1;
                    if (dat_pull != prev_dp) steady_err <= steady_err + 1;
                end
                if (in_ready) ready_err <= ready_err + 1;
            end else begin
                if (prev_cp) begin
                    rises <= rises + 1;
                    if (lowlen != PHW) width_err <= width_err + 1;
                    highlen <= 1;
                end else begin
                    highlen <= highlen + 1;
                end
            end
            if (prev_cp && !clk_pull) mid <= 1'b1;
            if (done || aborted) mid <= 1'b0;
            if (done) done_cnt <= done_cnt + 1;
            if (aborted) abort_cnt <= abort_cnt + 1;
            if (done && aborted) both_err <= both_err + 1;
            prev_cp <= clk_pull;
            prev_dp <= dat_pull;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_done();
        int base = done_cnt;
        int n = 0;
        while (done_cnt == base && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done_cnt != base, "R10 done seen", done_cnt - base, 1);
        @(negedge clk);
    endtask

    task automatic check_frame(input logic [7:0] b, input string req);
        chk(sr[0] == 1'b0, {req, " R1 start bit"}, int'(sr[0]), 0);
        chk(sr[8:1] == b, {req, " R1 data bits"}, int'(sr[8:1]), int'(b));
        chk(sr[9] == ~^b, {req, " R1 odd parity"}, int'(sr[9]), int'(~^b));
        chk(sr[10] == 1'b1, {req, " R1 stop bit"}, int'(sr[10]), 1);
    endtask

    // cycles from now until clk_pull is first seen high
    task automatic time_to_edge(output int n);
        n = 0;
        while (!clk_pull && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    initial begin
        int t;
        int rb, ab, db;
        repeat (5) @(negedge clk);
        // R11 reset state
        chk(!clk_pull, "R11 clk pull in reset", int'(clk_pull), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!clk_pull && !dat_pull, "R11 pulls idle", int'({clk_pull, dat_pull}), 0);
        chk(in_ready, "R11 ready", int'(in_ready), 1);
        chk(!done && !aborted, "R11 pulses low", int'({done, aborted}), 0);

        // R1 sweep over every byte value
        db = done_cnt;
        for (int b = 0; b < 256; b++) begin
            send(8'(b));
            wait_done();
            check_frame(8'(b), "sweep");
        end
        chk(done_cnt - db == 256, "R10 one done per frame", done_cnt - db, 256);
        chk(abort_cnt == 0, "R7 no spurious abort", abort_cnt, 0);
        chk(width_err == 0, "R3 clock phase widths", width_err, 0);
        chk(steady_err == 0, "R2 data steady in low", steady_err, 0);

        // R4 inhibit: host holds clock low
        host_clk_low = 1'b1;
        rb = rises;
        send(8'hA5);
        repeat (60) @(negedge clk);
        chk(rises == rb && !clk_pull, "R4 no clock while inhibited", rises - rb, 0);
        host_clk_low = 1'b0;
        time_to_edge(t);
        chk(t >= (IDLE + SETUP - 1) * P + 1 && t <= (IDLE + SETUP) * P,
            "R6 idle wait after inhibit", t, (IDLE + SETUP) * P);
        wait_done();
        check_frame(8'hA5, "R4");

        // R5 host request-to-send
        host_dat_low = 1'b1;
        rb = rises;
        send(8'h3C);
        repeat (60) @(negedge clk);
        chk(rises == rb && !clk_pull && !dat_pull, "R5 no start during request", rises - rb, 0);
        host_dat_low = 1'b0;
        wait_done();
        check_frame(8'h3C, "R5");

        // R6 glitch restarts the idle wait
        host_clk_low = 1'b1;
        send(8'h5A);
        repeat (10) @(negedge clk);
        host_clk_low = 1'b0;
        repeat (6) @(negedge clk);
        host_dat_low = 1'b1;
        @(negedge clk);
        host_dat_low = 1'b0;
        time_to_edge(t);
        chk(t >= (IDLE + SETUP - 1) * P + 1 && t <= (IDLE + SETUP) * P,
            "R6 idle wait after glitch", t, (IDLE + SETUP) * P);
        wait_done();
        check_frame(8'h5A, "R6");

        // R7/R8/R9 abort after the n-th rising edge
        for (int n = 1; n <= 10; n++) begin
            logic [7:0] b;
            int seen;
            logic pc;
            b  = 8'h96 ^ 8'(n * 37);
            ab = abort_cnt;
            send(b);
            seen = 0;
            pc = clk_pull;
            while (seen < n) begin
                @(negedge clk);
                if (pc && !clk_pull) seen++;
                pc = clk_pull;
            end
            host_clk_low = 1'b1;
            repeat (6) @(negedge clk);
            if (n <= 9) begin
                chk(abort_cnt == ab + 1, "R7 abort flagged", abort_cnt - ab, 1);
                chk(!clk_pull && !dat_pull, "R7 lines released", int'({clk_pull, dat_pull}), 0);
                rb = rises;
                repeat (30) @(negedge clk);
                chk(rises == rb && !in_ready, "R8 held while inhibited", rises - rb, 0);
                host_clk_low = 1'b0;
                wait_done();
                check_frame(b, "R8 retry");
                chk(abort_cnt == ab + 1, "R7 single abort", abort_cnt - ab, 1);
            end else begin
                chk(abort_cnt == ab, "R9 no abort after commit", abort_cnt - ab, 0);
                wait_done();
                host_clk_low = 1'b0;
                check_frame(b, "R9");
            end
        end

        // R8 byte offered while busy is not taken until done
        send(8'hC3);
        in_valid = 1'b1;
        in_data  = 8'h18;
        wait_done();
        in_valid = 1'b0;
        check_frame(8'hC3, "R8 busy");
        db = done_cnt;
        wait_done();
        check_frame(8'h18, "R8 next");
        repeat (300) @(negedge clk);
        chk(done_cnt == db + 1, "R8 single acceptance", done_cnt - db, 1);

        chk(width_err == 0, "R3 widths overall", width_err, 0);
        chk(steady_err == 0, "R2 steady overall", steady_err, 0);
        chk(ready_err == 0, "R8 ready while clocking", ready_err, 0);
        chk(both_err == 0, "R10 done with abort", both_err, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule